// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block generates the system reset for a processor domain. It watches a digital supply-good flag from an external comparator and keeps the reset output asserted while the flag is false, then for a programmable number of clock cycles after the flag comes back. The reset output can be built active-low or active-high through a parameter. The two polarities are exact logical inverses of each other.

A watchdog runs while reset is released. Software services it by toggling a kick input, where either edge counts. If the programmed period passes with no kick, the block fires a reset pulse as long as the reset timeout and then starts the watchdog again from zero. A mode input picks the base period or an extended period 500 times longer, and any change of that input also restarts the count. In extended mode a flag can mark the kick line as floating. The block then services itself at about fifteen sixteenths of the period, which disables the watchdog. A separate enable turns the watchdog off entirely.

The supply flag, kick, mode and float inputs each pass through a two-flop synchronizer. The reset length and the base watchdog period are 24-bit cycle counts. Each is latched whenever its counter restarts.

Top module: `rst_supervisor`

## Requirements
- R1: While the synchronous power-on input `por_n` is low, and on the first cycle after it rises, the reset output is asserted.
- R2: When `supply_ok` is low, reset is asserted within three clock cycles and stays asserted for as long as the flag stays low.
- R3: Suppose `supply_ok` rises before clock edge t1 while reset is asserted. Reset is then released after edge t(P+2), where P is `rst_period`, so it is seen asserted at P+1 samples after t1. A low pulse on `supply_ok` during that wait restarts the full count from the moment the flag returns.
- R4: A watchdog expiry asserts reset for exactly P cycles.
- R5: The watchdog counter is held at zero while reset is asserted and starts from zero at release. With no service, reset stays released for exactly L cycles, where L is the watchdog period.
- R6: A rising or a falling edge on `wd_kick` restarts the watchdog. If the edge is driven before edge tk, reset stays released through tk+L+2 at the earliest.
- R7: A change of level on `wd_mode_ext` restarts the watchdog, with the period chosen by the new level.
- R8: L is `wd_base_period` when `wd_mode_ext` is 0 and 500 times `wd_base_period` when it is 1. A period of 0 counts as 1.
- R9: With `wd_mode_ext`=1 and `wd_kick_float`=1, the watchdog never expires. With `wd_mode_ext`=0, `wd_kick_float` has no effect.
- R10: With `wd_enable`=0, no watchdog reset is ever issued.
- R11: With no service, the cycle of L released and P asserted repeats without end.
- R12: With ACTIVE_LOW=1, `rst_out` is 0 when reset is asserted. With ACTIVE_LOW=0, `rst_out` is its exact inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset of the block |
| supply_ok | input | 1 | Supply-good flag from the external comparator, asynchronous |
| wd_kick | input | 1 | Watchdog service line; either edge services it |
| wd_mode_ext | input | 1 | 0 selects the base period, 1 selects the period times 500 |
| wd_enable | input | 1 | 0 turns the watchdog off |
| wd_kick_float | input | 1 | Marks the service line as undriven |
| rst_period | input | 24 | Reset hold length in cycles |
| wd_base_period | input | 24 | Base watchdog period in cycles |
| rst_out | output | 1 | System reset with the polarity set by ACTIVE_LOW |

## Verification
The bench measures the exact run lengths of the reset output: the hold after supply return, the released time before an expiry, and the expiry pulse. An off-by-one in the counters or in synchronizer latency therefore shows up as a wrong count rather than going unnoticed. A one-cycle supply dip inside the hold window catches a design that resumes the old count instead of restarting it. Kicks on both edges and a mode flip while released catch a watchdog that reacts to only one edge or keeps the stale period. The floating-line cases in both modes, and the disabled watchdog, catch a self-service that leaks into normal mode or a watchdog that fires when it should be off.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int unsigned SUP_CNT_W       = 24;
    localparam int unsigned SUP_EXT_MULT    = 500;
    localparam int unsigned SUP_SYNC_STAGES = 2;

    // asynchronous inputs that share one synchronizer chain
    typedef struct packed {
        logic supply_ok;
        logic kick;
        logic mode_ext;
        logic kick_float;
    } sup_in_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned STAGES = sup_pkg::SUP_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             por_n,
    input  sup_pkg::sup_in_t raw,
    output sup_pkg::sup_in_t clean
);
    localparam int unsigned W = $bits(sup_pkg::sup_in_t);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = raw;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk) begin
                if (!por_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign clean = sup_pkg::sup_in_t'(stage_q[STAGES-1]);

endmodule

// File: rtl/sup_reset_timer.sv
module sup_reset_timer #(
    parameter int unsigned CNT_W = sup_pkg::SUP_CNT_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             supply_ok,
    input  logic             wd_expire,
    input  logic [CNT_W-1:0] period,
    output logic             rst_active
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
    } rt_state_t;

    rt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok || wd_expire) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.per    = period;
        end else if (st_q.active) begin
            if ({1'b0, st_q.cnt} + 1'b1 >= {1'b0, st_q.per}) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
            st_q.per    <= period;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_active = st_q.active;

    p_supply_low_asserts_r2: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> rst_active);

    p_expiry_asserts_r4: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |=> rst_active);

    p_release_needs_supply_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_active) |-> $past(supply_ok));

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int unsigned CNT_W    = sup_pkg::SUP_CNT_W,
    parameter int unsigned EXT_MULT = sup_pkg::SUP_EXT_MULT
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_active,
    input  logic             enable,
    input  logic             kick_s,
    input  logic             mode_s,
    input  logic             float_s,
    input  logic [CNT_W-1:0] base_period,
    output logic             expire
);
    localparam int unsigned LIM_W = CNT_W + $clog2(EXT_MULT) + 1;
    localparam logic [LIM_W-1:0] MULT_V = LIM_W'(EXT_MULT);
    localparam logic [LIM_W-1:0] ONE_V  = LIM_W'(1);

    typedef struct packed {
        logic             kick_prev;
        logic             mode_prev;
        logic             ext;
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
    } wd_state_t;

    wd_state_t st_d, st_q;

    logic             kick_edge, mode_edge, self_svc, clr;
    logic [LIM_W-1:0] base_w, new_lim, svc_pt, cnt_inc;

    always_comb begin
        base_w    = LIM_W'(base_period);
        new_lim   = mode_s ? base_w * MULT_V : base_w;
        if (new_lim == '0) new_lim = ONE_V;
        cnt_inc   = st_q.cnt + ONE_V;
        svc_pt    = st_q.lim - (st_q.lim >> 4);
        kick_edge = kick_s ^ st_q.kick_prev;
        mode_edge = mode_s ^ st_q.mode_prev;
        self_svc  = st_q.ext && float_s && (cnt_inc >= svc_pt);
        clr       = rst_active || kick_edge || mode_edge || self_svc;
        expire    = enable && !clr && (cnt_inc >= st_q.lim);

        st_d           = st_q;
        st_d.kick_prev = kick_s;
        st_d.mode_prev = mode_s;
        if (clr || !enable) begin
            st_d.cnt = '0;
            st_d.lim = new_lim;
            st_d.ext = mode_s;
        end else if (expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.kick_prev <= 1'b0;
            st_q.mode_prev <= 1'b0;
            st_q.ext       <= 1'b0;
            st_q.cnt       <= '0;
            st_q.lim       <= ONE_V;
        end else begin
            st_q <= st_d;
        end
    end

    p_held_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |=> (st_q.cnt == '0));

    p_kick_restarts_r6: assert property (@(posedge clk) disable iff (!por_n)
        (kick_s != $past(kick_s)) |=> (st_q.cnt == '0));

    p_mode_restarts_r7: assert property (@(posedge clk) disable iff (!por_n)
        (mode_s != $past(mode_s)) |=> (st_q.cnt == '0));

    p_float_ext_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.ext && float_s) |-> !expire);

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
        !enable |-> !expire);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned CNT_W       = sup_pkg::SUP_CNT_W,
    parameter int unsigned EXT_MULT    = sup_pkg::SUP_EXT_MULT,
    parameter int unsigned SYNC_STAGES = sup_pkg::SUP_SYNC_STAGES,
    parameter bit          ACTIVE_LOW  = 1'b1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             supply_ok,
    input  logic             wd_kick,
    input  logic             wd_mode_ext,
    input  logic             wd_enable,
    input  logic             wd_kick_float,
    input  logic [CNT_W-1:0] rst_period,
    input  logic [CNT_W-1:0] wd_base_period,
    output logic             rst_out
);
    sup_pkg::sup_in_t raw_in, sync_in;
    logic rst_active, wd_expire;

    assign raw_in = '{supply_ok: supply_ok, kick: wd_kick,
                      mode_ext: wd_mode_ext, kick_float: wd_kick_float};

    sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .raw   (raw_in),
        .clean (sync_in)
    );

    sup_reset_timer #(.CNT_W(CNT_W)) u_rtimer (
        .clk        (clk),
        .por_n      (por_n),
        .supply_ok  (sync_in.supply_ok),
        .wd_expire  (wd_expire),
        .period     (rst_period),
        .rst_active (rst_active)
    );

    sup_watchdog #(.CNT_W(CNT_W), .EXT_MULT(EXT_MULT)) u_wdog (
        .clk         (clk),
        .por_n       (por_n),
        .rst_active  (rst_active),
        .enable      (wd_enable),
        .kick_s      (sync_in.kick),
        .mode_s      (sync_in.mode_ext),
        .float_s     (sync_in.kick_float),
        .base_period (wd_base_period),
        .expire      (wd_expire)
    );

    generate
        if (ACTIVE_LOW) begin : g_low
            assign rst_out = ~rst_active;
        end else begin : g_high
            assign rst_out = rst_active;
        end
    endgenerate

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 4;
    localparam int TB_MODE [NTBL] = '{0, 0, 1, 0};
    localparam int TB_BASE [NTBL] = '{12, 33, 3, 50};
    localparam int TB_PER  [NTBL] = '{7, 1, 9, 25};

    logic clk = 1'b0;
    logic por_n, supply_ok, wd_kick, wd_mode_ext, wd_enable, wd_kick_float;
    logic [23:0] rst_period, wd_base_period;
    logic rst_out, rst_out_hi;
    int checks = 0, failures = 0, pol_mismatch = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_supervisor uut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wd_kick(wd_kick),
        .wd_mode_ext(wd_mode_ext), .wd_enable(wd_enable), .wd_kick_float(wd_kick_float),
        .rst_period(rst_period), .wd_base_period(wd_base_period), .rst_out(rst_out));

    rst_supervisor #(.ACTIVE_LOW(1'b0)) uut_hi (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wd_kick(wd_kick),
        .wd_mode_ext(wd_mode_ext), .wd_enable(wd_enable), .wd_kick_float(wd_kick_float),
        .rst_period(rst_period), .wd_base_period(wd_base_period), .rst_out(rst_out_hi));

    // R12 polarity watch, sampled away from the active edge
    always @(negedge clk) if (rst_out_hi !== ~rst_out) pol_mismatch++;

    function automatic bit asserted();
        return rst_out == 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_len(input bit lvl, input int cap, output int n);
        n = 0;
        while (asserted() == lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    // drop the supply, then raise it and measure the hold (R2, R3)
    task automatic dip_release(input int per);
        int n;
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        check(asserted(), "R2 asserted while supply low", int'(asserted()), 1);
        supply_ok = 1'b1;
        @(negedge clk);
        run_len(1'b1, 100000, n);
        check(n == per + 1, "R3 hold after supply return", n, per + 1);
    endtask

    initial begin
        int n;
        por_n = 1'b0; supply_ok = 1'b1; wd_kick = 1'b0; wd_mode_ext = 1'b0;
        wd_enable = 1'b1; wd_kick_float = 1'b0; rst_period = 24'd7; wd_base_period = 24'd12;
        repeat (5) @(negedge clk);
        check(asserted(), "R1 asserted during power-on reset", int'(asserted()), 1);
        check(rst_out_hi == 1'b1, "R12 high-polarity output during reset", int'(rst_out_hi), 1);
        por_n = 1'b1;
        @(negedge clk);
        check(asserted(), "R1 asserted after power-on release", int'(asserted()), 1);

        // table of modes and periods: hold, released, pulse, repeated (R3 R4 R5 R8 R11)
        for (int i = 0; i < NTBL; i++) begin
            int lim;
            lim = (TB_MODE[i] != 0) ? TB_BASE[i] * 500 : TB_BASE[i];
            wd_mode_ext = TB_MODE[i][0];
            wd_base_period = 24'(TB_BASE[i]);
            rst_period = 24'(TB_PER[i]);
            dip_release(TB_PER[i]);
            run_len(1'b0, 100000, n);
            check(n == lim, "R5 R8 released length before expiry", n, lim);
            run_len(1'b1, 100000, n);
            check(n == TB_PER[i], "R4 expiry pulse length", n, TB_PER[i]);
            run_len(1'b0, 100000, n);
            check(n == lim, "R11 second released length", n, lim);
            run_len(1'b1, 100000, n);
            check(n == TB_PER[i], "R11 second pulse length", n, TB_PER[i]);
        end

        // R3 dip during the hold restarts the count
        wd_mode_ext = 1'b0; wd_base_period = 24'd1000; rst_period = 24'd20;
        supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        supply_ok = 1'b1;
        repeat (6) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        run_len(1'b1, 100000, n);
        check(n == 22, "R3 restart after dip in hold", n, 22);

        // R6 rising then falling kick
        wd_base_period = 24'd40; rst_period = 24'd5;
        dip_release(5);
        repeat (10) @(negedge clk);
        wd_kick = 1'b1;
        run_len(1'b0, 100000, n);
        check(n == 43, "R6 rising kick restarts", n, 43);
        run_len(1'b1, 100000, n);
        check(n == 5, "R4 pulse after kicked run", n, 5);
        repeat (20) @(negedge clk);
        wd_kick = 1'b0;
        run_len(1'b0, 100000, n);
        check(n == 43, "R6 falling kick restarts", n, 43);
        run_len(1'b1, 100000, n);

        // R7 mode change while released restarts with the extended period (R8)
        repeat (10) @(negedge clk);
        wd_base_period = 24'd8;
        wd_mode_ext = 1'b1;
        run_len(1'b0, 100000, n);
        check(n == 4003, "R7 R8 mode change restarts with x500", n, 4003);
        run_len(1'b1, 100000, n);
        check(n == 5, "R4 pulse after extended run", n, 5);

        // R9 floating line in extended mode never expires
        wd_base_period = 24'd10; wd_kick_float = 1'b1;
        dip_release(5);
        run_len(1'b0, 20000, n);
        check(n == 20000, "R9 extended float never expires", n, 20000);

        // R9 floating line in normal mode has no effect
        wd_mode_ext = 1'b0; wd_base_period = 24'd30;
        dip_release(5);
        run_len(1'b0, 100000, n);
        check(n == 30, "R9 normal float still expires", n, 30);

        // R10 watchdog disabled
        wd_kick_float = 1'b0; wd_enable = 1'b0;
        dip_release(5);
        run_len(1'b0, 3000, n);
        check(n == 3000, "R10 disabled watchdog never fires", n, 3000);

        check(pol_mismatch == 0, "R12 polarity inverse mismatches", pol_mismatch, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule